// File: doc/BRIEF.md
# Bit-Serial Output-Stationary Multiplier Grid

This block is a grid of ROWS by COLS processing elements that multiplies an activation matrix (ROWS by DEPTH) with a weight matrix (DEPTH by COLS). Operands arrive one bit at a time. Each row has a single activation bit line that every element of that row sees. Each column has a single weight bit line that every element of that column sees. Each element collects eight activation bits and eight weight bits. It then multiplies the two values and adds the product to an accumulator that never leaves the element.

A controller pulses `start` and then presents the inner-dimension index k in order. For each k it sends the eight bit-pairs of activation column k and weight row k, most significant bit first, qualifying each bit with `bit_valid`. After DEPTH times eight qualified bits, every accumulator holds its entry of the product and `done` pulses.

Top module: `bsmac_grid`

## Requirements
- R1: While reset is asserted and after its release, every accumulator reads zero and `done` is low.
- R2: Operands are unsigned OPW-bit (8) values sent most significant bit first. The element at row r, column c multiplies the value from `act_bits[r]` with the value from `wgt_bits[c]`.
- R3: After DEPTH groups of eight qualified bits, the accumulator at (r,c) equals the sum over k of X[r][k]·W[k][c]. Element (r,c) occupies `acc_flat[(r*COLS+c)*ACCW +: ACCW]`, with ACCW = 2·OPW + clog2(DEPTH).
- R4: An accumulator changes only on the cycle that delivers the eighth bit of a group. The first seven bits of a group leave every accumulator unchanged.
- R5: A cycle with `bit_valid` low changes no accumulator, no bit count and no captured bit, whatever the bit lines carry.
- R6: `done` is high for exactly one cycle, right after the edge that takes the final bit. On that cycle the accumulators already hold the final sums. `done` is never high earlier.
- R7: `start` zeroes all accumulators on the next edge and restarts the bit and k counts, including in the middle of a computation. A bit presented together with `start` is dropped.
- R8: With every operand equal to the all-ones value, no accumulator overflows. Each reads DEPTH·(2^OPW−1)².
- R9: After completion, or before the first `start`, qualified bits have no effect until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears accumulators and counters and arms a computation |
| bit_valid | input | 1 | Qualifies the bits on the bit lines this cycle |
| act_bits | input | ROWS | One activation bit per row, shared along the row |
| wgt_bits | input | COLS | One weight bit per column, shared down the column |
| acc_flat | output | ROWS·COLS·ACCW | All accumulators, row-major |
| done | output | 1 | One-cycle pulse when the last product has been added |

## Verification
A bit counter that drifts by one step shows up at the ports within one group of eight bits. Either an accumulator moves on the wrong cycle, or it gains a product built from misaligned bits. A fault in the k counter shows only at the end of the run: `done` pulses early or late, and the totals are short or extra. The bench therefore checks accumulators part-way through a group, after idle gaps, and on the exact `done` cycle.

// File: rtl/bsmac_grid.sv
module bsmac_grid #(
  parameter int ROWS  = 2,
  parameter int COLS  = 3,
  parameter int DEPTH = 4,
  parameter int OPW   = 8,
  localparam int ACCW = 2*OPW + $clog2(DEPTH),
  localparam int KW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int BW   = $clog2(OPW)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       bit_valid,
  input  logic [ROWS-1:0]            act_bits,
  input  logic [COLS-1:0]            wgt_bits,
  output logic [ROWS*COLS*ACCW-1:0]  acc_flat,
  output logic                       done
);
  logic [BW-1:0] bit_cnt;
  logic [KW-1:0] k_cnt;
  logic          running;

  wire step     = running && bit_valid && !start;
  wire last_bit = step && (bit_cnt == BW'(OPW-1));
  wire last_k   = (k_cnt == KW'(DEPTH-1));

  logic [OPW-1:0] a_sh [ROWS];
  logic [OPW-1:0] w_sh [COLS];

  for (genvar r = 0; r < ROWS; r++) begin : g_arow
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)     a_sh[r] <= '0;
      else if (start) a_sh[r] <= '0;
      else if (step)  a_sh[r] <= {a_sh[r][OPW-2:0], act_bits[r]};
  end

  for (genvar c = 0; c < COLS; c++) begin : g_wcol
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)     w_sh[c] <= '0;
      else if (start) w_sh[c] <= '0;
      else if (step)  w_sh[c] <= {w_sh[c][OPW-2:0], wgt_bits[c]};
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_r
    for (genvar c = 0; c < COLS; c++) begin : g_c
      logic [OPW-1:0]   a_full, w_full;
      logic [2*OPW-1:0] prod;
      logic [ACCW-1:0]  acc;
      assign a_full = {a_sh[r][OPW-2:0], act_bits[r]};
      assign w_full = {w_sh[c][OPW-2:0], wgt_bits[c]};
      assign prod   = a_full * w_full;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)         acc <= '0;
        else if (start)     acc <= '0;
        else if (last_bit)  acc <= acc + ACCW'(prod);
      assign acc_flat[(r*COLS+c)*ACCW +: ACCW] = acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0;
      k_cnt   <= '0;
      running <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        bit_cnt <= '0;
        k_cnt   <= '0;
        running <= 1'b1;
      end else if (step) begin
        if (last_bit) begin
          bit_cnt <= '0;
          if (last_k) begin
            k_cnt   <= '0;
            running <= 1'b0;
            done    <= 1'b1;
          end else begin
            k_cnt <= k_cnt + KW'(1);
          end
        end else begin
          bit_cnt <= bit_cnt + BW'(1);
        end
      end
    end
endmodule

// File: rtl/bsmac_grid_chk.sv
module bsmac_grid_chk #(
  parameter int W = 1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         bit_valid,
  input logic [W-1:0] acc_flat,
  input logic         done
);
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !bit_valid) |=> ($stable(acc_flat) && !done));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(bit_valid) && !$past(start)));

  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (acc_flat == '0 && !done));

  always_comb
    if (!rst_n) a_r1_reset_state: assert (acc_flat == '0 && !done);
endmodule

bind bsmac_grid bsmac_grid_chk #(.W(ROWS*COLS*ACCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .bit_valid(bit_valid),
  .acc_flat(acc_flat), .done(done)
);

// File: tb/bsmac_grid_test.sv
module bsmac_grid_test;
  localparam int ROWS = 2, COLS = 3, DEPTH = 4, OPW = 8;
  localparam int ACCW = 2*OPW + $clog2(DEPTH);

  logic clk = 0, rst_n = 0, start = 0, bit_valid = 0;
  logic [ROWS-1:0] act_bits = '0;
  logic [COLS-1:0] wgt_bits = '0;
  logic [ROWS*COLS*ACCW-1:0] acc_flat;
  logic done;
  int checks = 0, errors = 0;

  logic [OPW-1:0] X [ROWS][DEPTH];
  logic [OPW-1:0] Wm [DEPTH][COLS];

  bsmac_grid #(.ROWS(ROWS), .COLS(COLS), .DEPTH(DEPTH), .OPW(OPW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_valid(bit_valid),
    .act_bits(act_bits), .wgt_bits(wgt_bits), .acc_flat(acc_flat), .done(done));

  always #2 clk = ~clk;

  function automatic logic [ACCW-1:0] acc_of(int r, int c);
    return acc_flat[(r*COLS+c)*ACCW +: ACCW];
  endfunction

  function automatic longint expect_sum(int r, int c, int kn);
    longint s = 0;
    for (int k = 0; k < kn; k++) s += longint'(X[r][k]) * longint'(Wm[k][c]);
    return s;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag, int kn);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        chk(tag, longint'(acc_of(r, c)), expect_sum(r, c, kn));
  endtask

  task automatic pulse_start();
    start = 1; bit_valid = 0;
    @(negedge clk);
    start = 0;
  endtask

  task automatic drive_bit(int k, int i);
    for (int r = 0; r < ROWS; r++) act_bits[r] = X[r][k][i];
    for (int c = 0; c < COLS; c++) wgt_bits[c] = Wm[k][c][i];
    bit_valid = 1;
    @(negedge clk);
    bit_valid = 0;
  endtask

  task automatic feed(int kn, bit gaps);
    for (int k = 0; k < kn; k++)
      for (int i = OPW-1; i >= 0; i--) begin
        drive_bit(k, i);
        if (gaps && i != 0) begin
          logic [ROWS*COLS*ACCW-1:0] snap = acc_flat;
          act_bits = '1; wgt_bits = '1;
          @(negedge clk);
          chk("R5 idle cycle keeps accumulators", longint'(acc_flat != snap), 0);
        end
      end
  endtask

  task automatic load_pattern(int seed);
    for (int r = 0; r < ROWS; r++)
      for (int k = 0; k < DEPTH; k++) X[r][k] = OPW'(r*71 + k*29 + seed*13 + 5);
    for (int k = 0; k < DEPTH; k++)
      for (int c = 0; c < COLS; c++) Wm[k][c] = OPW'(k*53 + c*37 + seed*7 + 1);
  endtask

  task automatic t_reset();
    chk("R1 reset accumulators", longint'(acc_flat != '0), 0);
    chk("R1 reset done", longint'(done), 0);
  endtask

  task automatic t_msb_first();
    load_pattern(1);
    X[0][0] = 8'h81; X[1][0] = 8'h06;
    Wm[0][0] = 8'h03; Wm[0][1] = 8'hC0; Wm[0][2] = 8'h11;
    pulse_start();
    for (int i = OPW-1; i >= 1; i--) drive_bit(0, i);
    chk_all("R4 no change before eighth bit", 0);
    drive_bit(0, 0);
    chk_all("R2 one product, msb first", 1);
    chk("R6 no early done", longint'(done), 0);
  endtask

  task automatic t_full(int seed, bit gaps);
    load_pattern(seed);
    pulse_start();
    feed(DEPTH, gaps);
    chk_all(gaps ? "R5 result with gaps" : "R3 full matrix product", DEPTH);
    chk("R6 done on final cycle", longint'(done), 1);
    @(negedge clk);
    chk("R6 done lasts one cycle", longint'(done), 0);
  endtask

  task automatic t_restart();
    load_pattern(3);
    pulse_start();
    feed(2, 0);
    chk_all("R3 partial after two groups", 2);
    for (int r = 0; r < ROWS; r++) act_bits[r] = 1'b1;
    start = 1; bit_valid = 1;
    @(negedge clk);
    start = 0; bit_valid = 0;
    chk("R7 start clears", longint'(acc_flat != '0), 0);
    load_pattern(4);
    feed(DEPTH, 0);
    chk_all("R7 clean result after restart", DEPTH);
    chk("R7 done after restart", longint'(done), 1);
    @(negedge clk);
  endtask

  task automatic t_max();
    for (int r = 0; r < ROWS; r++) for (int k = 0; k < DEPTH; k++) X[r][k] = '1;
    for (int k = 0; k < DEPTH; k++) for (int c = 0; c < COLS; c++) Wm[k][c] = '1;
    pulse_start();
    feed(DEPTH, 0);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        chk("R8 all-ones no overflow", longint'(acc_of(r, c)), longint'(DEPTH) * 65025);
    @(negedge clk);
  endtask

  task automatic t_after_done();
    logic [ROWS*COLS*ACCW-1:0] snap;
    load_pattern(5);
    pulse_start();
    feed(DEPTH, 0);
    @(negedge clk);
    snap = acc_flat;
    for (int n = 0; n < 2*OPW; n++) begin
      act_bits = '1; wgt_bits = '1; bit_valid = 1;
      @(negedge clk);
      chk("R9 bits after done ignored (done)", longint'(done), 0);
    end
    bit_valid = 0;
    chk("R9 bits after done ignored (acc)", longint'(acc_flat != snap), 0);
  endtask

  task automatic t_before_start();
    act_bits = '1; wgt_bits = '1;
    for (int n = 0; n < OPW; n++) begin
      bit_valid = 1;
      @(negedge clk);
    end
    bit_valid = 0;
    chk("R9 bits before start ignored", longint'(acc_flat != '0), 0);
    chk("R9 no done before start", longint'(done), 0);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_before_start();
    t_msb_first();
    t_full(2, 0);
    t_full(6, 1);
    t_restart();
    t_max();
    t_after_done();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule